// File: doc/BRIEF.md
# Iterative Fractal Image Decoder

This block rebuilds a small greyscale image from its fractal code. On start it clears its working frame to black and then runs decoding passes. Each pass has two phases. First it derives a codebook from the frame the previous pass left: each entry is a 4x4 tile obtained by averaging 2x2 pixel groups of an 8x8 window. Then it regenerates every 4x4 region of the image as a scaled codebook tile plus an offset. The index, scale and offset for each region come from an external code memory.

The new frame goes to a second buffer, and the two buffers trade roles when a pass ends. A pass therefore only ever reads the frame of the pass before it. Decoding ends on the first pass that changes no pixel, or when a caller-supplied pass limit is reached, whichever comes first. The block then pulses a completion flag. The finished image can be read through a combinational pixel port, and a counter reports how many passes were run.

With the default 16x16 image there are 16 regions. The codebook windows step by 4 pixels in each direction, which gives 3x3 = 9 entries. One pass takes 144 codebook cycles, 256 region-pixel cycles and one turnover cycle, 401 cycles in all.

Top module: `frac_decoder`

## Requirements
- R1: After reset, busy, done and iter_count are all 0.
- R2: A start pulse seen while idle zeroes the working frame, clears iter_count and begins pass 1 in the next cycle. A start seen while busy has no effect on timing or results.
- R3: Codebook entry e = ey*3+ex (ex, ey in 0..2) covers the 8x8 window whose top-left pixel is (4*ex, 4*ey). Its pixel u+4*v (u, v in 0..3) is floor of the sum of the four frame pixels at x 4*ex+2u+{0,1}, y 4*ey+2v+{0,1}, divided by 4. The frame used is the one at the start of the pass.
- R4: Region r covers x 4*(r%4)..+3, y 4*(r/4)..+3. Its pixel u+4*v becomes floor(s*D/4)+o. Here D is pixel u+4*v of the chosen entry, s is the decoded scale in quarters, and o is code_ofs as a 9-bit two's complement value.
- R5: Scale codes 0..7 stand for +4, +3, +2, +1, -1, -2, -3, -4 quarters.
- R6: Rebuilt pixels are clamped to 0..255.
- R7: A code index of 9 or more selects entry 0.
- R8: A pass writes only the spare buffer. pix_data shows the previous pass's frame unchanged until the pass's turnover cycle ends.
- R9: Decoding stops after the first pass in which no pixel changed, or after max_pass passes if that comes first. A max_pass of 0 runs exactly one pass.
- R10: For P passes, busy is high for exactly P*401 cycles after the start edge. done is high for a single cycle, the next one.
- R11: iter_count increases by one at the end of each pass and holds its final value until the next start.
- R12: pix_data combinationally returns pixel pix_addr = y*16+x of the current frame.
- R13: During the region phase, code_addr equals the region being rebuilt. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a decode when idle |
| max_pass | input | 4 | Pass limit, sampled at start (0 means 1) |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle completion pulse |
| iter_count | output | 4 | Passes run so far |
| code_addr | output | 4 | Region whose code is being read |
| code_idx | input | 4 | Codebook entry for code_addr |
| code_scale | input | 3 | Scale code for code_addr |
| code_ofs | input | 9 | Signed offset for code_addr |
| pix_addr | input | 8 | Pixel read address |
| pix_data | output | 8 | Pixel of the current frame |

## Verification
The bench sweeps pix_addr on every cycle and compares pix_data against the reference frame for the pass in progress. A pixel that is wrong, or a buffer that turns over on the wrong cycle, therefore shows up within one pass and usually within a few cycles. A wrong codebook entry or a misdecoded scale stays hidden until the next turnover cycle, and then shows on the pixel port and in the final frame dump. A wrong stop decision shifts the done cycle by a whole 401-cycle pass, and busy and iter_count expose it on that exact cycle.

// File: rtl/fdec_pkg.sv
`timescale 1ns/1ps
package fdec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BUILD  = 2'd1,
    ST_APPLY  = 2'd2,
    ST_FINISH = 2'd3
  } fdec_state_e;

  // Scale code to signed quarter steps: 0..3 -> 4..1, 4..7 -> -1..-4
  function automatic logic signed [3:0] scale_quarters(input logic [2:0] code);
    logic signed [3:0] q;
    if (!code[2]) q = 4'sd4 - $signed({2'b00, code[1:0]});
    else          q = -4'sd1 - $signed({2'b00, code[1:0]});
    return q;
  endfunction

  function automatic logic [7:0] clamp_u8(input logic signed [11:0] v);
    logic [7:0] r;
    if (v < 12'sd0)        r = 8'd0;
    else if (v > 12'sd255) r = 8'hFF;
    else                   r = v[7:0];
    return r;
  endfunction

endpackage

// File: rtl/fdec_pixel_unit.sv
`timescale 1ns/1ps
module fdec_pixel_unit
  import fdec_pkg::*;
(
  input  logic [7:0]        cb_pix,
  input  logic [2:0]        scale_code,
  input  logic signed [8:0] ofs,
  output logic [7:0]        pix_out
);

  logic signed [3:0]  s_q;
  logic signed [12:0] s_ext;
  logic signed [12:0] d_ext;
  logic signed [12:0] prod;
  logic signed [10:0] scaled;
  logic signed [11:0] sum;

  always_comb begin
    s_q    = scale_quarters(scale_code);
    s_ext  = $signed({{9{s_q[3]}}, s_q});
    d_ext  = $signed({5'b0_0000, cb_pix});
    prod   = d_ext * s_ext;
    scaled = prod[12:2];
    sum    = $signed({scaled[10], scaled}) + $signed({{3{ofs[8]}}, ofs});
    pix_out = clamp_u8(sum);
  end

endmodule

// File: rtl/fdec_frame_store.sv
`timescale 1ns/1ps
module fdec_frame_store #(
  parameter int IMG_W = 16,
  parameter int IMG_H = 16,
  parameter int AW    = 8,
  parameter int NRD   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_cur,
  input  logic                     swap,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [7:0]               wr_data,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  output logic [NRD-1:0][7:0]      rd_data
);

  localparam int NPIX = IMG_W * IMG_H;

  logic [7:0] bank0 [NPIX];
  logic [7:0] bank1 [NPIX];
  logic       cur_sel_q;
  logic       cur_sel_d;

  // current bank is cur_sel_q; writes always land in the other one
  always_ff @(posedge clk) begin
    if (clr_cur && !cur_sel_q) begin
      for (int i = 0; i < NPIX; i++) bank0[i] <= 8'd0;
    end else if (wr_en && cur_sel_q) begin
      bank0[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (clr_cur && cur_sel_q) begin
      for (int i = 0; i < NPIX; i++) bank1[i] <= 8'd0;
    end else if (wr_en && !cur_sel_q) begin
      bank1[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    cur_sel_d = cur_sel_q;
    if (swap) cur_sel_d = ~cur_sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_sel_q <= 1'b0;
    else        cur_sel_q <= cur_sel_d;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = cur_sel_q ? bank1[rd_addr[g]] : bank0[rd_addr[g]];
  end

  AST_CLEAR_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cur |-> !wr_en);  // R2
  AST_SWAP_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    swap |-> !wr_en);  // R8

endmodule

// File: rtl/fdec_codebook.sv
`timescale 1ns/1ps
module fdec_codebook #(
  parameter int IMG_W   = 16,
  parameter int IMG_H   = 16,
  parameter int CB_STEP = 4,
  parameter int AW      = 8,
  parameter int IDXW    = 4,
  parameter int CW      = 8
) (
  input  logic                 clk,
  input  logic                 build_en,
  input  logic [CW-1:0]        build_cnt,
  output logic [3:0][AW-1:0]   fr_addr,
  input  logic [3:0][7:0]      fr_data,
  input  logic [IDXW-1:0]      sel_idx,
  input  logic [3:0]           sel_pix,
  output logic [7:0]           cb_pix
);

  localparam int CBX   = (IMG_W - 8) / CB_STEP + 1;
  localparam int CBY   = (IMG_H - 8) / CB_STEP + 1;
  localparam int NENT  = CBX * CBY;
  localparam int NCB   = NENT * 16;
  localparam int CBAW  = $clog2(NCB);

  logic [7:0]      cb_mem [NCB];
  logic [9:0]      quad_sum;
  logic [7:0]      quad_avg;
  logic [CBAW-1:0] wr_slot;
  logic [CBAW-1:0] rd_slot;

  // window addresses for the codebook pixel being built
  always_comb begin
    int ent, pix, bx, by;
    ent = int'(build_cnt) / 16;
    pix = int'(build_cnt) % 16;
    bx  = (ent % CBX) * CB_STEP + 2 * (pix % 4);
    by  = (ent / CBX) * CB_STEP + 2 * (pix / 4);
    for (int k = 0; k < 4; k++) begin
      fr_addr[k] = AW'((by + k / 2) * IMG_W + bx + k % 2);
    end
  end

  always_comb begin
    quad_sum = 10'(fr_data[0]) + 10'(fr_data[1]) + 10'(fr_data[2]) + 10'(fr_data[3]);
    quad_avg = quad_sum[9:2];
    wr_slot  = CBAW'(build_cnt);
  end

  always_ff @(posedge clk) begin
    if (build_en) cb_mem[wr_slot] <= quad_avg;
  end

  always_comb begin
    int ent_sel;
    ent_sel = int'(sel_idx);
    if (ent_sel >= NENT) ent_sel = 0;
    rd_slot = CBAW'(ent_sel * 16 + int'(sel_pix));
    cb_pix  = cb_mem[rd_slot];
  end

endmodule

// File: rtl/fdec_ctrl.sv
`timescale 1ns/1ps
module fdec_ctrl
  import fdec_pkg::*;
#(
  parameter int NCB  = 144,
  parameter int NPIX = 256,
  parameter int ITW  = 4,
  parameter int CW   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [ITW-1:0] max_pass,
  input  logic           pix_changed,
  output logic           busy,
  output logic           done,
  output logic [ITW-1:0] iter_count,
  output logic           clr_cur,
  output logic           cb_en,
  output logic           ap_en,
  output logic           swap,
  output logic [CW-1:0]  cnt
);

  fdec_state_e    state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [ITW-1:0] iter_q, iter_d;
  logic [ITW-1:0] lim_q, lim_d;
  logic           chg_q, chg_d;
  logic           done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    iter_d  = iter_q;
    lim_d   = lim_q;
    chg_d   = chg_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_BUILD;
          cnt_d   = '0;
          iter_d  = '0;
          chg_d   = 1'b0;
          lim_d   = (max_pass == '0) ? ITW'(1) : max_pass;
        end
      end
      ST_BUILD: begin
        if (int'(cnt_q) == NCB - 1) begin
          state_d = ST_APPLY;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_APPLY: begin
        chg_d = chg_q | pix_changed;
        if (int'(cnt_q) == NPIX - 1) begin
          state_d = ST_FINISH;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_FINISH: begin
        iter_d = iter_q + ITW'(1);
        if (!chg_q || (iter_d == lim_q)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_BUILD;
          chg_d   = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      iter_q  <= '0;
      lim_q   <= ITW'(1);
      chg_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      iter_q  <= iter_d;
      lim_q   <= lim_d;
      chg_q   <= chg_d;
      done_q  <= done_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign iter_count = iter_q;
  assign clr_cur    = (state_q == ST_IDLE) && start;
  assign cb_en      = (state_q == ST_BUILD);
  assign ap_en      = (state_q == ST_APPLY);
  assign swap       = (state_q == ST_FINISH);
  assign cnt        = cnt_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R10
  AST_DONE_FOLLOWS_TURNOVER: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(state_q) == ST_FINISH) && !busy);  // R10
  AST_ITER_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (iter_count < lim_q));  // R9
  AST_START_ZEROES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (iter_count == '0));  // R11

endmodule

// File: rtl/frac_decoder.sv
`timescale 1ns/1ps
module frac_decoder #(
  parameter int IMG_W   = 16,
  parameter int IMG_H   = 16,
  parameter int CB_STEP = 4,
  parameter int ITER_W  = 4
) (
  input  logic                                                   clk,
  input  logic                                                   rst_n,
  input  logic                                                   start,
  input  logic [ITER_W-1:0]                                      max_pass,
  output logic                                                   busy,
  output logic                                                   done,
  output logic [ITER_W-1:0]                                      iter_count,
  output logic [$clog2((IMG_W/4)*(IMG_H/4))-1:0]                 code_addr,
  input  logic [$clog2(((IMG_W-8)/CB_STEP+1)*((IMG_H-8)/CB_STEP+1))-1:0] code_idx,
  input  logic [2:0]                                             code_scale,
  input  logic signed [8:0]                                      code_ofs,
  input  logic [$clog2(IMG_W*IMG_H)-1:0]                         pix_addr,
  output logic [7:0]                                             pix_data
);

  localparam int NPIX = IMG_W * IMG_H;
  localparam int AW   = $clog2(NPIX);
  localparam int RXN  = IMG_W / 4;
  localparam int NREG = RXN * (IMG_H / 4);
  localparam int RW   = $clog2(NREG);
  localparam int NENT = ((IMG_W - 8) / CB_STEP + 1) * ((IMG_H - 8) / CB_STEP + 1);
  localparam int IDXW = $clog2(NENT);
  localparam int NCB  = NENT * 16;
  localparam int CW   = $clog2((NPIX > NCB) ? NPIX : NCB);
  localparam int NRD  = 6;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  logic                   clr_cur, cb_en, ap_en, swap, pix_changed;
  logic [CW-1:0]          cnt;
  logic [AW-1:0]          wr_addr;
  logic [RW-1:0]          region;
  logic [7:0]             cb_pix, new_pix;
  logic [3:0][AW-1:0]     cb_fr_addr;
  logic [3:0][7:0]        cb_fr_data;
  logic [NRD-1:0][AW-1:0] fs_rd_addr;
  logic [NRD-1:0][7:0]    fs_rd_data;

  fdec_ctrl #(.NCB(NCB), .NPIX(NPIX), .ITW(ITER_W), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start(start), .max_pass(max_pass),
    .pix_changed(pix_changed), .busy(busy), .done(done),
    .iter_count(iter_count), .clr_cur(clr_cur), .cb_en(cb_en),
    .ap_en(ap_en), .swap(swap), .cnt(cnt)
  );

  // region pixel address for the apply phase
  always_comb begin
    int rr, pp;
    rr = int'(cnt) / 16;
    pp = int'(cnt) % 16;
    region  = RW'(rr);
    wr_addr = AW'(((rr / RXN) * 4 + pp / 4) * IMG_W + (rr % RXN) * 4 + pp % 4);
  end

  assign code_addr = ap_en ? region : '0;

  fdec_codebook #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .CB_STEP(CB_STEP),
    .AW(AW), .IDXW(IDXW), .CW(CW)
  ) u_cb (
    .clk(clk), .build_en(cb_en), .build_cnt(cnt),
    .fr_addr(cb_fr_addr), .fr_data(cb_fr_data),
    .sel_idx(code_idx), .sel_pix(cnt[3:0]), .cb_pix(cb_pix)
  );

  fdec_pixel_unit u_pix (
    .cb_pix(cb_pix), .scale_code(code_scale), .ofs(code_ofs), .pix_out(new_pix)
  );

  always_comb begin
    for (int k = 0; k < 4; k++) fs_rd_addr[k] = cb_fr_addr[k];
    fs_rd_addr[4] = wr_addr;
    fs_rd_addr[5] = pix_addr;
    for (int k = 0; k < 4; k++) cb_fr_data[k] = fs_rd_data[k];
  end

  fdec_frame_store #(.IMG_W(IMG_W), .IMG_H(IMG_H), .AW(AW), .NRD(NRD)) u_fs (
    .clk(clk), .rst_n(rst_int_n), .clr_cur(clr_cur), .swap(swap),
    .wr_en(ap_en), .wr_addr(wr_addr), .wr_data(new_pix),
    .rd_addr(fs_rd_addr), .rd_data(fs_rd_data)
  );

  assign pix_changed = ap_en && (new_pix != fs_rd_data[4]);
  assign pix_data    = fs_rd_data[5];

  AST_CODE_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |-> (code_addr == '0));  // R13
  AST_PASS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_int_n)
    swap |=> (iter_count == $past(iter_count) + ITER_W'(1)));  // R11

endmodule

// File: tb/frac_decoder_tb.sv
`timescale 1ns/1ps
module frac_decoder_tb;

  localparam int PASS_CYC = 401;
  localparam int BUILD_CYC = 144;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [3:0] max_pass;
  logic busy, done;
  logic [3:0] iter_count, code_addr, code_idx;
  logic [2:0] code_scale;
  logic signed [8:0] code_ofs;
  logic [7:0] pix_addr, pix_data;

  int c_idx [16];
  int c_scl [16];
  int c_ofs [16];
  int frm [17][256];
  int npass;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  frac_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .max_pass(max_pass),
    .busy(busy), .done(done), .iter_count(iter_count),
    .code_addr(code_addr), .code_idx(code_idx), .code_scale(code_scale),
    .code_ofs(code_ofs), .pix_addr(pix_addr), .pix_data(pix_data)
  );

  // code memory answers combinationally
  always_comb begin
    code_idx   = 4'(c_idx[code_addr]);
    code_scale = 3'(c_scl[code_addr]);
    code_ofs   = 9'(c_ofs[code_addr]);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int quarters(input int code);   // R5 table
    case (code)
      0: return 4;  1: return 3;  2: return 2;  3: return 1;
      4: return -1; 5: return -2; 6: return -3; default: return -4;
    endcase
  endfunction

  function automatic int floor4(input int t);
    if (t >= 0) return t / 4;
    return -((-t + 3) / 4);
  endfunction

  // behavioural reference: whole passes on integer frames
  task automatic model_run(input int lim);
    int cb [9][16];
    int eff;
    eff = (lim == 0) ? 1 : lim;   // R9 zero limit
    for (int a = 0; a < 256; a++) frm[0][a] = 0;
    npass = eff;
    for (int k = 1; k <= eff; k++) begin
      bit same;
      for (int e = 0; e < 9; e++)            // R3 codebook windows
        for (int p = 0; p < 16; p++) begin
          int x, y, s;
          x = (e % 3) * 4 + 2 * (p % 4);
          y = (e / 3) * 4 + 2 * (p / 4);
          s = frm[k-1][y*16+x] + frm[k-1][y*16+x+1]
            + frm[k-1][(y+1)*16+x] + frm[k-1][(y+1)*16+x+1];
          cb[e][p] = s / 4;
        end
      same = 1'b1;
      for (int r = 0; r < 16; r++)
        for (int p = 0; p < 16; p++) begin
          int e, v, a;
          e = (c_idx[r] >= 9) ? 0 : c_idx[r];   // R7
          v = floor4(quarters(c_scl[r]) * cb[e][p]) + c_ofs[r];
          if (v < 0) v = 0;                       // R6
          if (v > 255) v = 255;
          a = ((r / 4) * 4 + p / 4) * 16 + (r % 4) * 4 + p % 4;
          frm[k][a] = v;
          if (v != frm[k-1][a]) same = 1'b0;
        end
      if (same) begin npass = k; break; end
    end
  endtask

  task automatic run_case(input string name, input int lim, input int poke);
    int last;
    model_run(lim);
    last = npass * PASS_CYC + 3;
    @(negedge clk);
    max_pass = 4'(lim);
    start = 1'b1;
    @(negedge clk);
    for (int c = 1; c <= last; c++) begin
      int k, q, ea;
      bit eb;
      start = (c == poke);           // R2 start while busy is ignored
      pix_addr = 8'(c % 256);
      #1;
      eb = (c <= npass * PASS_CYC);
      k = (c - 1) / PASS_CYC;
      if (k > npass) k = npass;
      q = (c - 1) % PASS_CYC;
      ea = (eb && q >= BUILD_CYC && q < PASS_CYC - 1) ? (q - BUILD_CYC) / 16 : 0;
      chk({name, " R10 busy"}, int'(busy), int'(eb));
      chk({name, " R10 done"}, int'(done), int'(c == npass * PASS_CYC + 1));
      chk({name, " R11 iter_count"}, int'(iter_count), k);
      chk({name, " R13 code_addr"}, int'(code_addr), ea);
      chk({name, " R8 R12 pix_data"}, int'(pix_data), frm[k][c % 256]);
      @(negedge clk);
    end
    start = 1'b0;
    for (int a = 0; a < 256; a++) begin   // R4 final frame
      pix_addr = 8'(a);
      #1;
      chk({name, " R4 final pixel"}, int'(pix_data), frm[npass][a]);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    max_pass = 4'd0;
    pix_addr = 8'd0;
    for (int r = 0; r < 16; r++) begin c_idx[r] = 0; c_scl[r] = 0; c_ofs[r] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 done at reset", int'(done), 0);
    chk("R1 iter_count at reset", int'(iter_count), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", int'(busy), 0);

    // converging contraction, scale +1/4 (R3 R4 R5 R9), start poked mid-run (R2)
    for (int r = 0; r < 16; r++) begin c_idx[r] = r % 9; c_scl[r] = 3; c_ofs[r] = 40 + 5 * r; end
    run_case("contract", 15, 200);

    // mixed scale codes including negative ones, stopped by the limit (R5 R9)
    for (int r = 0; r < 16; r++) begin
      c_idx[r] = int'($urandom_range(8, 0));
      c_scl[r] = int'($urandom_range(7, 0));
      c_ofs[r] = int'($urandom_range(191, 0)) - 64;
    end
    run_case("mixed", 3, 0);

    // clamping at both ends (R6)
    for (int r = 0; r < 16; r++) begin
      c_idx[r] = r % 9;
      c_scl[r] = (r % 2 == 0) ? 0 : 7;
      c_ofs[r] = (r % 2 == 0) ? 255 : -100;
    end
    run_case("clamp", 15, 0);

    // out-of-range entry numbers fall back to entry 0 (R7)
    for (int r = 0; r < 16; r++) begin c_idx[r] = 9 + (r % 7); c_scl[r] = 1; c_ofs[r] = 20 + r; end
    c_idx[0] = 0; c_idx[5] = 4;
    run_case("badidx", 15, 0);

    // zero limit runs one pass (R9), restart from a swapped buffer clears it (R2)
    for (int r = 0; r < 16; r++) begin c_idx[r] = r % 9; c_scl[r] = 3; c_ofs[r] = 40 + 5 * r; end
    run_case("zerolim", 0, 100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule